// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This block is the interrupt entry logic of a small 32-bit processor core. Six request latches sit in a control register, and six per-source enables sit in a flags register. When no interrupt is in service and at least one latched source is also enabled, the block picks the highest-numbered one. It then runs the entry sequence on its own. It sets the in-service mask, pre-decrements the stack pointer register R31 by four, and stores a pipeline-corrected return address at the new stack address. Finally it loads the program counter (and R30) with the per-source vector and flushes the pipeline.

The surrounding core holds instruction issue while `busy` is high. It supplies the current PC, the current R31 value and a code for what sits in the execute stage. It accepts register-file and memory writes from the block. A host writes the control register through its own port, and that path leaves the version field and the latches alone. Software writes the flags register. Clearing the in-service mask while a request is pending starts a new dispatch at once.

Top module: `irq_dispatch`

## Requirements
- R1: Request line i (0..5) is latched in `ctrl_q` at bit 6+i for i<5 and at bit 15 for i=5. A cycle with `req_strobe[i]` high copies `req_level[i]` into that bit on the next clock edge.
- R2: A host write to the control register leaves bits 31:28 (version, reset value `VERSION_ID`) and the six latch bits unchanged; every other bit takes the written value.
- R3: The enable for source i is `flags_q` bit 4+i for i<5 and bit 16 for i=5; a latched source whose enable is clear is never dispatched.
- R4: No dispatch starts while `flags_q[3]` (in-service mask) is set, or while no source is both latched and enabled; `busy` stays low in that case.
- R5: When several sources are latched and enabled, the highest index is dispatched.
- R6: The clock edge that ends the arbitration cycle sets `flags_q[3]`. `bank_sel` equals `flags_q[14]` AND NOT `flags_q[3]`.
- R7: The cycle after arbitration drives `rf_we` with `rf_waddr`=31 and `rf_wdata` = `sp_in` - 4.
- R8: The following cycle raises `mem_valid`, with `mem_addr` = the decremented stack value. `mem_valid`, `mem_addr` and `mem_wdata` hold until `mem_ready` is seen high.
- R9: `mem_wdata` = PC - 2 - k, with PC and `ex_kind` sampled in the arbitration cycle. k is 6 for `ex_kind`=2'b10 (long move-immediate), 0 for 2'b01 (bubble), and 2 for 2'b00 or 2'b11.
- R10: After the store, a single cycle drives `pc_load`, `flush`, and `rf_we` to register 30, with `pc_value` = `rf_wdata` = 0xF1B000 + 16 * source index.
- R11: Clearing `flags_q[3]` while a latched source is enabled makes `busy` high in the very next cycle and dispatches that source.
- R12: `busy` is high from the arbitration cycle through the vector cycle: four cycles when `mem_ready` is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_strobe | input | 6 | Per-line update strobe for the request latches |
| req_level | input | 6 | New level for each strobed latch |
| host_wr_en | input | 1 | Host control-register write |
| host_wr_data | input | 32 | Host write data |
| ctrl_q | output | 32 | Control register contents |
| flags_wr_en | input | 1 | Software flags-register write |
| flags_wr_data | input | 32 | Flags write data |
| flags_q | output | 32 | Flags register contents |
| bank_sel | output | 1 | Register bank select |
| pc_in | input | 32 | Current program counter |
| ex_kind | input | 2 | Execute-stage content code |
| sp_in | input | 32 | Current R31 value |
| busy | output | 1 | Hold instruction issue |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| pc_load | output | 1 | Load new PC |
| pc_value | output | 32 | New PC value |
| flush | output | 1 | Flush the pipeline |

## Verification
The assertions assume that the core keeps `pc_in`, `sp_in` and `ex_kind` steady while `busy` is high. They also assume that software does not write the flags register during a dispatch, and that `mem_ready` eventually rises. The stimulus changes those inputs only while `busy` is low. It writes flags only between sequences, and it releases `mem_ready` after a bounded stall. Request strobes and host writes are applied at any time, including while a sequence is running, since the latch and control logic must accept them then.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int unsigned XLEN     = 32;
    localparam int unsigned NSRC     = 6;
    localparam int unsigned IDXW     = $clog2(NSRC);

    // control register layout
    localparam int unsigned CTL_LAT_LO = 6;
    localparam int unsigned CTL_LAT_HI = 15;
    localparam int unsigned CTL_VER_LO = 28;
    localparam int unsigned CTL_VER_W  = 4;

    // flags register layout
    localparam int unsigned FLG_EN_LO  = 4;
    localparam int unsigned FLG_EN_HI  = 16;
    localparam int unsigned FLG_MASK   = 3;
    localparam int unsigned FLG_BANK   = 14;

    localparam logic [4:0] SP_REG   = 5'd31;
    localparam logic [4:0] LINK_REG = 5'd30;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SPDEC  = 2'd1,
        PH_STORE  = 2'd2,
        PH_VECTOR = 2'd3
    } phase_e;

    localparam logic [1:0] EX_BUBBLE  = 2'b01;
    localparam logic [1:0] EX_LONGIMM = 2'b10;

    function automatic int unsigned lat_pos(input int unsigned src);
        return (src < NSRC - 1) ? CTL_LAT_LO + src : CTL_LAT_HI;
    endfunction

    function automatic int unsigned en_pos(input int unsigned src);
        return (src < NSRC - 1) ? FLG_EN_LO + src : FLG_EN_HI;
    endfunction

    function automatic logic [XLEN-1:0] protect_mask();
        logic [XLEN-1:0] m;
        m = '0;
        for (int i = 0; i < NSRC; i++) m[lat_pos(i)] = 1'b1;
        for (int i = 0; i < CTL_VER_W; i++) m[CTL_VER_LO + i] = 1'b1;
        return m;
    endfunction

    function automatic logic [XLEN-1:0] ret_addr(input logic [XLEN-1:0] pc,
                                                 input logic [1:0] kind);
        logic [XLEN-1:0] adj;
        if (kind == EX_LONGIMM)     adj = 32'd6;
        else if (kind == EX_BUBBLE) adj = 32'd0;
        else                        adj = 32'd2;
        return pc - 32'd2 - adj;
    endfunction

endpackage

// File: rtl/irqd_ctrl.sv
module irqd_ctrl
    import irqd_pkg::*;
#(
    parameter logic [CTL_VER_W-1:0] VERSION_ID = 4'h2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr_en,
    input  logic [XLEN-1:0] host_wr_data,
    input  logic [NSRC-1:0] req_strobe,
    input  logic [NSRC-1:0] req_level,
    output logic [XLEN-1:0] ctrl_q,
    output logic [NSRC-1:0] pending
);
    localparam logic [XLEN-1:0] PROT = protect_mask();

    typedef struct packed {
        logic [XLEN-1:0] ctrl;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (host_wr_en)
            st_d.ctrl = (st_q.ctrl & PROT) | (host_wr_data & ~PROT);
        for (int i = 0; i < NSRC; i++) begin
            if (req_strobe[i]) st_d.ctrl[lat_pos(i)] = req_level[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl <= '0;
            st_q.ctrl[CTL_VER_LO +: CTL_VER_W] <= VERSION_ID;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q = st_q.ctrl;

    for (genvar g = 0; g < NSRC; g++) begin : g_pend
        assign pending[g] = st_q.ctrl[lat_pos(g)];
    end

    AST_VERSION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(ctrl_q[CTL_VER_LO +: CTL_VER_W]))
        else $error("version field changed"); // R2

    AST_LATCH_HOST_BLIND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_strobe == '0) |=> $stable(pending))
        else $error("latch moved without strobe"); // R1

endmodule

// File: rtl/irqd_arb.sv
module irqd_arb
    import irqd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pending,
    input  logic [NSRC-1:0] enable,
    input  logic            in_service,
    output logic            want,
    output logic [IDXW-1:0] idx
);
    logic [NSRC-1:0] live;

    assign live = pending & enable;
    assign want = !in_service && (live != '0);

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (live[i]) idx = IDXW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && want) begin
            AST_PICK_HIGHEST: assert (live[idx] && ((live >> idx) == 1))
                else $error("arbiter chose a lower source"); // R5
        end
    end

endmodule

// File: rtl/irqd_seq.sv
module irqd_seq
    import irqd_pkg::*;
#(
    parameter logic [XLEN-1:0] VEC_BASE   = 32'h00F1_B000,
    parameter int unsigned     STRIDE_LG2 = 4,
    parameter logic [XLEN-1:0] SP_STEP    = 32'd4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            want,
    input  logic [IDXW-1:0] idx,
    input  logic            flags_wr_en,
    input  logic [XLEN-1:0] flags_wr_data,
    input  logic [XLEN-1:0] pc_in,
    input  logic [1:0]      ex_kind,
    input  logic [XLEN-1:0] sp_in,
    input  logic            mem_ready,
    output logic [XLEN-1:0] flags_q,
    output logic            in_service,
    output logic            bank_sel,
    output logic            busy,
    output logic            rf_we,
    output logic [4:0]      rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            mem_valid,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_value,
    output logic            flush
);
    typedef struct packed {
        phase_e          phase;
        logic [IDXW-1:0] idx;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] ret;
        logic [XLEN-1:0] flags;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [XLEN-1:0] vector;

    assign vector = VEC_BASE + (XLEN'(st_q.idx) << STRIDE_LG2);

    always_comb begin
        st_d      = st_q;
        rf_we     = 1'b0;
        rf_waddr  = '0;
        rf_wdata  = '0;
        mem_valid = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pc_load   = 1'b0;
        pc_value  = '0;
        flush     = 1'b0;
        if (flags_wr_en) st_d.flags = flags_wr_data;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (want) begin
                    st_d.flags[FLG_MASK] = 1'b1;
                    st_d.idx   = idx;
                    st_d.ret   = ret_addr(pc_in, ex_kind);
                    st_d.phase = PH_SPDEC;
                end
            end
            PH_SPDEC: begin
                rf_we      = 1'b1;
                rf_waddr   = SP_REG;
                rf_wdata   = sp_in - SP_STEP;
                st_d.sp    = sp_in - SP_STEP;
                st_d.phase = PH_STORE;
            end
            PH_STORE: begin
                mem_valid = 1'b1;
                mem_addr  = st_q.sp;
                mem_wdata = st_q.ret;
                if (mem_ready) st_d.phase = PH_VECTOR;
            end
            PH_VECTOR: begin
                pc_load    = 1'b1;
                flush      = 1'b1;
                pc_value   = vector;
                rf_we      = 1'b1;
                rf_waddr   = LINK_REG;
                rf_wdata   = vector;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, idx: '0, sp: '0, ret: '0, flags: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q    = st_q.flags;
    assign in_service = st_q.flags[FLG_MASK];
    assign bank_sel   = st_q.flags[FLG_BANK] & ~st_q.flags[FLG_MASK];
    assign busy       = (st_q.phase != PH_IDLE) || want;

    AST_MASK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && want) |=> in_service)
        else $error("mask not set on dispatch"); // R6

    AST_NO_DISPATCH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && in_service) |=> (st_q.phase == PH_IDLE))
        else $error("dispatch while masked"); // R4

    AST_STORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)))
        else $error("store dropped before ready"); // R8

    AST_STORE_FOLLOWS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr == SP_REG) |=> (mem_valid && mem_addr == $past(rf_wdata)))
        else $error("store address mismatch"); // R7

    AST_PC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load)
        else $error("pc load longer than one cycle"); // R10

    AST_BUSY_COVERS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || pc_load || rf_we) |-> busy)
        else $error("sequence ran without busy"); // R12

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irqd_pkg::*;
#(
    parameter logic [CTL_VER_W-1:0] VERSION_ID = 4'h2,
    parameter logic [XLEN-1:0]      VEC_BASE   = 32'h00F1_B000,
    parameter int unsigned          STRIDE_LG2 = 4,
    parameter logic [XLEN-1:0]      SP_STEP    = 32'd4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_strobe,
    input  logic [NSRC-1:0] req_level,
    input  logic            host_wr_en,
    input  logic [XLEN-1:0] host_wr_data,
    output logic [XLEN-1:0] ctrl_q,
    input  logic            flags_wr_en,
    input  logic [XLEN-1:0] flags_wr_data,
    output logic [XLEN-1:0] flags_q,
    output logic            bank_sel,
    input  logic [XLEN-1:0] pc_in,
    input  logic [1:0]      ex_kind,
    input  logic [XLEN-1:0] sp_in,
    output logic            busy,
    output logic            rf_we,
    output logic [4:0]      rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_value,
    output logic            flush
);
    logic [NSRC-1:0] pending;
    logic [NSRC-1:0] enable;
    logic            in_service;
    logic            want;
    logic [IDXW-1:0] idx;

    irqd_ctrl #(.VERSION_ID(VERSION_ID)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .req_strobe   (req_strobe),
        .req_level    (req_level),
        .ctrl_q       (ctrl_q),
        .pending      (pending)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_en
        assign enable[g] = flags_q[en_pos(g)];
    end

    irqd_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .enable     (enable),
        .in_service (in_service),
        .want       (want),
        .idx        (idx)
    );

    irqd_seq #(
        .VEC_BASE   (VEC_BASE),
        .STRIDE_LG2 (STRIDE_LG2),
        .SP_STEP    (SP_STEP)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .want          (want),
        .idx           (idx),
        .flags_wr_en   (flags_wr_en),
        .flags_wr_data (flags_wr_data),
        .pc_in         (pc_in),
        .ex_kind       (ex_kind),
        .sp_in         (sp_in),
        .mem_ready     (mem_ready),
        .flags_q       (flags_q),
        .in_service    (in_service),
        .bank_sel      (bank_sel),
        .busy          (busy),
        .rf_we         (rf_we),
        .rf_waddr      (rf_waddr),
        .rf_wdata      (rf_wdata),
        .mem_valid     (mem_valid),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .pc_load       (pc_load),
        .pc_value      (pc_value),
        .flush         (flush)
    );

    AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_valid && !pc_load && !rf_we) |-> ((pending & enable) != '0))
        else $error("arbitration without enabled source"); // R3

endmodule

// File: tb/test_irq_dispatch.sv
module test_irq_dispatch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  req_strobe = '0;
    logic [5:0]  req_level = '0;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic [31:0] ctrl_q;
    logic        flags_wr_en = 1'b0;
    logic [31:0] flags_wr_data = '0;
    logic [31:0] flags_q;
    logic        bank_sel;
    logic [31:0] pc_in = 32'h00F1_B100;
    logic [1:0]  ex_kind = 2'b00;
    logic [31:0] sp_in = 32'h00F1_BFF0;
    logic        busy;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        pc_load;
    logic [31:0] pc_value;
    logic        flush;

    always #5 clk = ~clk;

    irq_dispatch i_irq_dispatch (
        .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe), .req_level(req_level),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .ctrl_q(ctrl_q),
        .flags_wr_en(flags_wr_en), .flags_wr_data(flags_wr_data), .flags_q(flags_q),
        .bank_sel(bank_sel), .pc_in(pc_in), .ex_kind(ex_kind), .sp_in(sp_in),
        .busy(busy), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pc_load(pc_load), .pc_value(pc_value), .flush(flush)
    );

    localparam logic [31:0] KEEP = 32'hF000_87C0;
    localparam logic [31:0] RST_CTRL = 32'h2000_0000;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // behavioural reference state
    logic [31:0] m_ctrl, m_flags, m_sp, m_ret;
    int          m_ph, m_idx;

    logic [31:0] last_vec, last_ret, last_spw;
    int          busy_cnt;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    function automatic bit m_want();
        logic [5:0] p, e;
        p = {m_ctrl[15], m_ctrl[10:6]};
        e = {m_flags[16], m_flags[8:4]};
        return (m_ph == 0) && !m_flags[3] && ((p & e) != 0);
    endfunction

    function automatic int m_pick();
        logic [5:0] p, e;
        int r;
        p = {m_ctrl[15], m_ctrl[10:6]};
        e = {m_flags[16], m_flags[8:4]};
        r = 0;
        for (int i = 5; i >= 0; i--) if (p[i] && e[i]) begin r = i; break; end
        return r;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL R12 watchdog actual=%0d expected=%0d", cyc, 20000);
            summary();
        end
        if (!rst_n) begin
            m_ctrl = RST_CTRL; m_flags = 0; m_ph = 0; m_idx = 0; m_sp = 0; m_ret = 0;
        end else begin
            logic [31:0] nc, nf;
            bit w;
            int hi;
            w = m_want();
            hi = m_pick();
            nc = m_ctrl;
            if (host_wr_en) nc = (m_ctrl & KEEP) | (host_wr_data & ~KEEP);
            for (int i = 0; i < 6; i++) if (req_strobe[i]) nc[(i < 5) ? 6 + i : 15] = req_level[i];
            nf = m_flags;
            if (flags_wr_en) nf = flags_wr_data;
            if (w) nf[3] = 1'b1;
            case (m_ph)
                0: if (w) begin
                       m_idx = hi;
                       m_ret = pc_in - 2 - ((ex_kind == 2'b10) ? 6 : (ex_kind == 2'b01) ? 0 : 2);
                       m_ph = 1;
                   end
                1: begin m_sp = sp_in - 4; m_ph = 2; end
                2: if (mem_ready) m_ph = 3;
                default: m_ph = 0;
            endcase
            m_ctrl = nc;
            m_flags = nf;
        end
    end

    task automatic compare();
        logic [31:0] vec;
        vec = 32'h00F1_B000 + 32'(m_idx) * 16;
        chk(ctrl_q == m_ctrl, "R1 ctrl", ctrl_q, m_ctrl);
        chk(flags_q == m_flags, "R6 flags", flags_q, m_flags);
        chk(bank_sel == (m_flags[14] & ~m_flags[3]), "R6 bank_sel", 32'(bank_sel), 32'(m_flags[14] & ~m_flags[3]));
        chk(busy == ((m_ph != 0) || m_want()), "R12 busy", 32'(busy), 32'((m_ph != 0) || m_want()));
        chk(rf_we == (m_ph == 1 || m_ph == 3), "R7 rf_we", 32'(rf_we), 32'(m_ph == 1 || m_ph == 3));
        if (m_ph == 1) begin
            chk(rf_waddr == 5'd31, "R7 rf_waddr", 32'(rf_waddr), 32'd31);
            chk(rf_wdata == sp_in - 4, "R7 rf_wdata", rf_wdata, sp_in - 4);
        end
        chk(mem_valid == (m_ph == 2), "R8 mem_valid", 32'(mem_valid), 32'(m_ph == 2));
        if (m_ph == 2) begin
            chk(mem_addr == m_sp, "R8 mem_addr", mem_addr, m_sp);
            chk(mem_wdata == m_ret, "R9 mem_wdata", mem_wdata, m_ret);
        end
        chk(pc_load == (m_ph == 3), "R10 pc_load", 32'(pc_load), 32'(m_ph == 3));
        chk(flush == (m_ph == 3), "R10 flush", 32'(flush), 32'(m_ph == 3));
        if (m_ph == 3) begin
            chk(pc_value == vec, "R10 pc_value", pc_value, vec);
            chk(rf_waddr == 5'd30 && rf_wdata == vec, "R10 link write", rf_wdata, vec);
        end
        if (busy) busy_cnt++;
        if (pc_load) last_vec = pc_value;
        if (mem_valid) last_ret = mem_wdata;
        if (rf_we && rf_waddr == 5'd31) last_spw = rf_wdata;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
        req_strobe = '0;
        host_wr_en = 1'b0;
        flags_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            if (!busy) break;
            tick();
        end
    endtask

    task automatic raise(input logic [5:0] lines, input logic [5:0] lvl);
        req_strobe = lines;
        req_level = lvl;
    endtask

    task automatic set_flags(input logic [31:0] v);
        flags_wr_en = 1'b1;
        flags_wr_data = v;
    endtask

    initial begin
        last_vec = 0; last_ret = 0; last_spw = 0; busy_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_q == RST_CTRL, "R2 reset ctrl", ctrl_q, RST_CTRL);
        chk(flags_q == 0 && !busy, "R4 reset idle", flags_q, 0);

        // dispatch source 2, plain execute slot, bank bit set
        set_flags(32'h0001_41F0);
        tick();
        chk(bank_sel == 1'b1, "R6 bank before entry", 32'(bank_sel), 1);
        raise(6'b000100, 6'b000100);
        busy_cnt = 0;
        tick();
        chk(ctrl_q[8] == 1'b1, "R1 latch bit 8", ctrl_q, ctrl_q | 32'h100);
        wait_idle();
        chk(busy_cnt == 4, "R12 busy length", busy_cnt, 4);
        chk(last_spw == 32'h00F1_BFEC, "R7 sp write", last_spw, 32'h00F1_BFEC);
        chk(last_vec == 32'h00F1_B020, "R10 vector src2", last_vec, 32'h00F1_B020);
        chk(last_ret == 32'h00F1_B0FC, "R9 plain ret", last_ret, 32'h00F1_B0FC);
        chk(flags_q[3] && !bank_sel, "R6 mask set", flags_q, flags_q | 8);

        // more requests while masked: nothing may start
        raise(6'b100010, 6'b100010);
        tick();
        chk(ctrl_q[15] == 1'b1, "R1 latch bit 15", ctrl_q, ctrl_q | 32'h8000);
        for (int i = 0; i < 4; i++) tick();
        chk(!busy, "R4 masked hold", 32'(busy), 0);

        // unmask: highest (5) wins, long move-immediate in execute
        ex_kind = 2'b10;
        set_flags(32'h0001_01F0);
        tick();
        chk(busy, "R11 redispatch on unmask", 32'(busy), 1);
        wait_idle();
        chk(last_vec == 32'h00F1_B050, "R5 highest source", last_vec, 32'h00F1_B050);
        chk(last_ret == 32'h00F1_B0F8, "R9 long immediate ret", last_ret, 32'h00F1_B0F8);

        // drop 5 and 2, bubble in execute, stalled store
        raise(6'b100100, 6'b000000);
        tick();
        ex_kind = 2'b01;
        mem_ready = 1'b0;
        set_flags(32'h0001_01F0);
        for (int i = 0; i < 6; i++) tick();
        chk(mem_valid && mem_addr == 32'h00F1_BFEC, "R8 held store", mem_addr, 32'h00F1_BFEC);
        mem_ready = 1'b1;
        wait_idle();
        chk(last_vec == 32'h00F1_B010, "R10 vector src1", last_vec, 32'h00F1_B010);
        chk(last_ret == 32'h00F1_B0FE, "R9 bubble ret", last_ret, 32'h00F1_B0FE);

        // enable gating: only source 5 enabled, only source 0 latched
        raise(6'b000011, 6'b000001);
        tick();
        ex_kind = 2'b11;
        set_flags(32'h0001_0000);
        for (int i = 0; i < 4; i++) tick();
        chk(!busy && !flags_q[3], "R3 disabled source ignored", 32'(busy), 0);
        set_flags(32'h0001_0010);
        tick();
        wait_idle();
        chk(last_vec == 32'h00F1_B000, "R3 source 0 enabled", last_vec, 32'h00F1_B000);
        chk(last_ret == 32'h00F1_B0FC, "R9 code 3 ret", last_ret, 32'h00F1_B0FC);

        // host writes leave version and latches alone
        host_wr_en = 1'b1;
        host_wr_data = 32'hFFFF_FFFF;
        tick();
        chk((ctrl_q & KEEP) == 32'h2000_0040, "R2 protected after ones", ctrl_q & KEEP, 32'h2000_0040);
        chk((ctrl_q & ~KEEP) == 32'h0FFF_783F, "R2 open bits after ones", ctrl_q & ~KEEP, 32'h0FFF_783F);
        host_wr_en = 1'b1;
        host_wr_data = 32'h0;
        raise(6'b001000, 6'b001000);
        tick();
        chk(ctrl_q == 32'h2000_0240, "R2 zero write with strobe", ctrl_q, 32'h2000_0240);
        for (int i = 0; i < 3; i++) tick();
        summary();
    end

endmodule